// File: doc/BRIEF.md
# PCM Timeslot Serial Port with Loopback

This block is the serial PCM datapath of a voice codec. Once per frame an external slot strobe announces an eight-bit timeslot. During the slot the block shifts one PCM word in from the receive serial line and hands it in parallel to the decoder. At the same time it shifts one word out on the transmit serial line, which it drives only for those eight bit clocks. Words travel sign bit first, which is also the most significant bit. The analog filters and converters are outside the block. Only the parallel encoder and decoder words and a loopback select output stand for them.

A control word (`ctrl_a`) sets the operating mode and carries two gain fields, which the block decodes for the analog side. In digital loopback the word received in one slot is sent back out in the next accepted slot. In that mode the decoder sees zeros and the encoder word is discarded. In analog loopback the block asserts a select that routes the receive filter into the transmit path, and it sends the encoder result as usual. In powerdown slots are refused and the power enable drops. A slot flagged as a control slot is passed over: nothing is sampled and nothing is driven.

The slot controller has three states:
- `ST_IDLE`, waiting for a strobe.
- `ST_XFER`, eight bit clocks of data transfer.
- `ST_SKIP`, eight bit clocks of an inhibited slot.

It has four transitions:
- IDLE→XFER when a strobe arrives without inhibit and the block is not in powerdown.
- IDLE→SKIP when a strobe arrives with inhibit and the block is not in powerdown.
- XFER→IDLE on the last bit.
- SKIP→IDLE on the last bit.

In powerdown, or with no strobe, the controller stays in IDLE.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset `tx_oe` is 0, `dec_word` is 0 and `dec_valid` is 0.
- R2: A strobe accepted at clock edge e0 makes `tx_oe` high for exactly the eight cycles between edge e0 and edge e8. Outside those eight cycles `tx_oe` stays low.
- R3: In the k-th cycle of the slot (k = 0..7), `tx_bit` carries bit 7−k of the word loaded at e0, so the MSB (sign bit) goes first. While `tx_oe` is low, `tx_bit` is 0.
- R4: `rx_ser` is sampled at edges e1..e8, and the first sample becomes bit 7. At e8 `dec_word` takes the new word, and `dec_valid` is high for the single cycle that follows.
- R5: The mode is `ctrl_a[7:6]`: 00 normal, 01 digital loopback, 10 analog loopback, 11 powerdown.
- R6: In normal and analog loopback mode, the word sent is `enc_word` as it stood at e0.
- R7: In digital loopback, the word sent is the word received in the previous accepted slot (0 if there was none). The word written to `dec_word` is 0.
- R8: `aloop_sel` is 1 exactly when the mode is 10. In that mode the decoder receives the incoming word unchanged.
- R9: In powerdown `pwr_en` is 0 and strobes are ignored: `tx_oe` stays low and `dec_word`/`dec_valid` do not change.
- R10: A strobe with `slot_inhibit` = 1 starts an eight-cycle skipped slot. During it nothing is driven and nothing is sampled, so `dec_word` and the loopback word keep their values.
- R11: `tx_gain` = `ctrl_a[2:0]` (transmit gain +N dB) and `rx_atten` = `ctrl_a[5:3]` (receive gain −N dB).
- R12: A strobe that arrives while a slot is in progress is ignored. The slot still ends after eight cycles and no new slot starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | One-cycle strobe in the cycle before the first bit of the slot |
| slot_inhibit | input | 1 | Qualifies the strobe as a control slot (no PCM) |
| ctrl_a | input | 8 | Control word: mode [7:6], receive gain [5:3], transmit gain [2:0] |
| rx_ser | input | 1 | Receive serial data, MSB first |
| enc_word | input | 8 | Parallel word from the encoder |
| tx_bit | output | 1 | Transmit serial data, valid when `tx_oe` is high |
| tx_oe | output | 1 | Transmit output enable (low means high impedance) |
| dec_word | output | 8 | Parallel word to the decoder |
| dec_valid | output | 1 | One-cycle pulse when `dec_word` is updated |
| aloop_sel | output | 1 | Routes the receive filter into the transmit path |
| pwr_en | output | 1 | Analog power enable |
| tx_gain | output | 3 | Transmit gain step, +N dB |
| rx_atten | output | 3 | Receive gain step, −N dB |

## Verification
Suppose the slot controller holds the wrong state or bit count. `tx_oe` then shows a window of the wrong length, or one that reopens, within the same slot. `dec_valid` lands on the wrong cycle nine edges after the strobe. Suppose instead the loopback word is stale or captured from the wrong slot. That error only shows one frame later, as the wrong serial word, so the stimulus chains several digital-loopback slots, with skipped and powerdown slots in between, to expose it. A wrong bit order is visible on the very first transmitted bit and in the word delivered to the decoder.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_DIGLOOP = 2'b01,
        PM_ANALOOP = 2'b10,
        PM_POWERDN = 2'b11
    } pcm_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_XFER = 2'b01,
        ST_SKIP = 2'b10
    } slot_state_e;

endpackage

// File: rtl/pcm_mode_decode.sv
module pcm_mode_decode
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int GAIN_W = 3
) (
    input  logic [WORD_W-1:0] ctrl_a,
    output pcm_mode_e         mode,
    output logic [GAIN_W-1:0] tx_gain,
    output logic [GAIN_W-1:0] rx_atten,
    output logic              aloop_sel,
    output logic              pwr_en
);
    localparam int MODE_LSB = WORD_W - 2;
    localparam int RXG_LSB  = GAIN_W;

    always_comb begin
        mode      = pcm_mode_e'(ctrl_a[MODE_LSB +: 2]);
        tx_gain   = ctrl_a[0 +: GAIN_W];
        rx_atten  = ctrl_a[RXG_LSB +: GAIN_W];
        aloop_sel = (mode == PM_ANALOOP);
        pwr_en    = (mode != PM_POWERDN);
    end

endmodule

// File: rtl/pcm_slot_fsm.sv
module pcm_slot_fsm
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_start,
    input  logic slot_inhibit,
    input  logic power_down,
    output logic in_xfer,
    output logic in_skip,
    output logic load_tx,
    output logic last_bit
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    slot_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (slot_start && !power_down)
                         state_nx = slot_inhibit ? ST_SKIP : ST_XFER;
            ST_XFER: if (at_end) state_nx = ST_IDLE;
            ST_SKIP: if (at_end) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // bit counter, cleared outside slots
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (state == ST_IDLE) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    // outputs
    always_comb begin
        in_xfer  = (state == ST_XFER);
        in_skip  = (state == ST_SKIP);
        load_tx  = (state == ST_IDLE) && slot_start && !slot_inhibit && !power_down;
        last_bit = in_xfer && at_end;
    end

endmodule

// File: rtl/pcm_shift_path.sv
module pcm_shift_path #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_tx,
    input  logic              shift_en,
    input  logic              last_bit,
    input  logic              dig_loop,
    input  logic [WORD_W-1:0] enc_word,
    input  logic              rx_ser,
    output logic              tx_msb,
    output logic [WORD_W-1:0] dec_word,
    output logic              dec_valid
);
    logic [WORD_W-1:0] tx_sh, rx_sh, lb_word, rx_full;

    assign rx_full = {rx_sh[WORD_W-2:0], rx_ser};
    assign tx_msb  = tx_sh[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load_tx)       tx_sh <= dig_loop ? lb_word : enc_word;
            else if (shift_en) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            if (shift_en)      rx_sh <= rx_full;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lb_word   <= '0;
            dec_word  <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= last_bit;
            if (last_bit) begin
                lb_word  <= rx_full;
                dec_word <= dig_loop ? '0 : rx_full;
            end
        end
    end

endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int GAIN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_start,
    input  logic              slot_inhibit,
    input  logic [WORD_W-1:0] ctrl_a,
    input  logic              rx_ser,
    input  logic [WORD_W-1:0] enc_word,
    output logic              tx_bit,
    output logic              tx_oe,
    output logic [WORD_W-1:0] dec_word,
    output logic              dec_valid,
    output logic              aloop_sel,
    output logic              pwr_en,
    output logic [GAIN_W-1:0] tx_gain,
    output logic [GAIN_W-1:0] rx_atten
);
    pcm_mode_e mode;
    logic in_xfer, in_skip, load_tx, last_bit, tx_msb;

    pcm_mode_decode #(.WORD_W(WORD_W), .GAIN_W(GAIN_W)) i_dec (
        .ctrl_a(ctrl_a), .mode(mode), .tx_gain(tx_gain), .rx_atten(rx_atten),
        .aloop_sel(aloop_sel), .pwr_en(pwr_en)
    );

    pcm_slot_fsm #(.WORD_W(WORD_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
        .slot_inhibit(slot_inhibit), .power_down(!pwr_en),
        .in_xfer(in_xfer), .in_skip(in_skip), .load_tx(load_tx),
        .last_bit(last_bit)
    );

    pcm_shift_path #(.WORD_W(WORD_W)) i_path (
        .clk(clk), .rst_n(rst_n), .load_tx(load_tx), .shift_en(in_xfer),
        .last_bit(last_bit), .dig_loop(mode == PM_DIGLOOP),
        .enc_word(enc_word), .rx_ser(rx_ser), .tx_msb(tx_msb),
        .dec_word(dec_word), .dec_valid(dec_valid)
    );

    assign tx_oe  = in_xfer && pwr_en;
    assign tx_bit = tx_oe && tx_msb;

endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_start,
    input logic [1:0]        mode_bits,
    input logic              tx_oe,
    input logic              pwr_en,
    input logic              dec_valid,
    input logic [WORD_W-1:0] dec_word,
    input logic              in_xfer,
    input logic              in_skip
);
    p_xfer_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_xfer) |-> $past(slot_start));

    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_valid_after_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_xfer));

    p_dloop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(mode_bits) == 2'b01) |-> (dec_word == '0));

    p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !tx_oe);

    p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_skip |-> !tx_oe);

    p_one_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_xfer, in_skip}));

endmodule

bind pcm_slot_port pcm_slot_port_chk #(.WORD_W(WORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .mode_bits(ctrl_a[WORD_W-1 -: 2]), .tx_oe(tx_oe), .pwr_en(pwr_en),
    .dec_valid(dec_valid), .dec_word(dec_word),
    .in_xfer(in_xfer), .in_skip(in_skip)
);

// File: tb/test_pcm_slot_port.sv
module test_pcm_slot_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_start = 1'b0;
    logic       slot_inhibit = 1'b0;
    logic [7:0] ctrl_a = 8'h00;
    logic       rx_ser = 1'b0;
    logic [7:0] enc_word = 8'h00;
    logic       tx_bit, tx_oe, dec_valid, aloop_sel, pwr_en;
    logic [7:0] dec_word;
    logic [2:0] tx_gain, rx_atten;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pcm_slot_port i_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
        .slot_inhibit(slot_inhibit), .ctrl_a(ctrl_a), .rx_ser(rx_ser),
        .enc_word(enc_word), .tx_bit(tx_bit), .tx_oe(tx_oe),
        .dec_word(dec_word), .dec_valid(dec_valid), .aloop_sel(aloop_sel),
        .pwr_en(pwr_en), .tx_gain(tx_gain), .rx_atten(rx_atten)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       inh;
        logic [7:0] enc;
        logic [7:0] rx;
        logic       drv;
        logic [7:0] tx;
        logic [7:0] dec;
    } vec_t;

    // mode, inhibit, enc, rx, expect drive, expect tx word, expect dec_word
    localparam vec_t VEC [10] = '{
        '{2'b00, 1'b0, 8'hA5, 8'h3C, 1'b1, 8'hA5, 8'h3C},
        '{2'b00, 1'b0, 8'h5A, 8'h81, 1'b1, 8'h5A, 8'h81},
        '{2'b01, 1'b0, 8'hFF, 8'h7E, 1'b1, 8'h81, 8'h00},
        '{2'b01, 1'b0, 8'h00, 8'hC3, 1'b1, 8'h7E, 8'h00},
        '{2'b10, 1'b0, 8'h96, 8'h0F, 1'b1, 8'h96, 8'h0F},
        '{2'b00, 1'b1, 8'h11, 8'h22, 1'b0, 8'h00, 8'h0F},
        '{2'b01, 1'b0, 8'h33, 8'hE7, 1'b1, 8'h0F, 8'h00},
        '{2'b11, 1'b0, 8'h44, 8'h55, 1'b0, 8'h00, 8'h00},
        '{2'b01, 1'b0, 8'h12, 8'h34, 1'b1, 8'hE7, 8'h00},
        '{2'b00, 1'b0, 8'h80, 8'h01, 1'b1, 8'h80, 8'h01}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_slot(input vec_t v, output logic [7:0] oe_seen, output logic [7:0] tx_seen);
        @(negedge clk);
        ctrl_a = {v.mode, 6'b000000};
        enc_word = v.enc;
        slot_inhibit = v.inh;
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        slot_inhibit = 1'b0;
        for (int k = 0; k < 8; k++) begin
            rx_ser = v.rx[7-k];
            oe_seen[7-k] = tx_oe;
            tx_seen[7-k] = tx_bit;
            @(negedge clk);
        end
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] oe_w, tx_w;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tx_oe", tx_oe, 0);
        check("R1 dec_word", dec_word, 0);
        check("R1 dec_valid", dec_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            run_slot(VEC[i], oe_w, tx_w);
            // at the negedge after e8
            check("R2/R9/R10 drive window", oe_w, VEC[i].drv ? 8'hFF : 8'h00);
            check("R3/R6/R7 tx word", tx_w, VEC[i].tx);
            check("R2 tx_oe after slot", tx_oe, 0);
            check("R4/R7/R8/R9/R10 dec_word", dec_word, VEC[i].dec);
            check("R4/R9/R10 dec_valid", dec_valid, VEC[i].drv);
            check("R5/R8 aloop_sel", aloop_sel, VEC[i].mode == 2'b10);
            check("R5/R9 pwr_en", pwr_en, VEC[i].mode != 2'b11);
            @(negedge clk);
            check("R4 dec_valid single", dec_valid, 0);
        end

        // R12: strobe in mid-slot is ignored
        ctrl_a = 8'h00;
        enc_word = 8'hC6;
        @(negedge clk);
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            slot_start = (k == 3);
            rx_ser = 1'b1;
            oe_w[7-k] = tx_oe;
            tx_w[7-k] = tx_bit;
            @(negedge clk);
        end
        slot_start = 1'b0;
        check("R12 window", oe_w, 8'hFF);
        check("R12 word", tx_w, 8'hC6);
        check("R12 no restart", tx_oe, 0);
        @(negedge clk);
        check("R12 no restart later", tx_oe, 0);
        check("R4 all ones received", dec_word, 8'hFF);

        // R11 gain fields
        ctrl_a = 8'b00_011_010;
        @(negedge clk);
        check("R11 tx_gain", tx_gain, 3'd2);
        check("R11 rx_atten", rx_atten, 3'd3);
        ctrl_a = 8'b11_111_000;
        @(negedge clk);
        check("R11 tx_gain pd", tx_gain, 3'd0);
        check("R11 rx_atten pd", rx_atten, 3'd7);
        check("R9 pwr_en low", pwr_en, 0);
        check("R3 tx_bit idle", tx_bit, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule